// File: doc/BRIEF.md
# Row Tag Buffer Controller for an In-Row-Tagged DRAM Cache

This block fronts a DRAM cache that keeps each row's block tags inside that same row, next to the cached data. Keeping the full tag store in DRAM would normally cost two device accesses per lookup: one to fetch the tags and one to move the data. To avoid that, the controller holds a small direct-mapped on-chip buffer. Each buffer entry stores the complete tag set of one recently used row.

A request carries an address that is split into a cache tag, a row index and a block-within-row index. The low bits of the row index select a buffer entry. The remaining row bits are compared against the entry's row tag. When the buffer holds the row, the cache hit or miss is known at once, and a single data command goes to the DRAM. When it does not, three steps run in order:

- If the victim entry is dirty, its tags are written back to their row.
- The requested row's tags are read from DRAM and installed in the buffer.
- The data command is issued. It is flagged as a row-buffer hit, because the metadata read has just opened that row.

A cache miss turns the data command into a fill. The fill places the new tag in the buffer entry and marks the entry dirty, so the in-row copy is brought up to date when that entry is evicted. Only one request is in flight at a time. The request side and the DRAM command side each use a ready/valid handshake.

Top module: `tag_buffer_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and dram_valid and rsp_valid are both 0.
- R2: When the buffer holds the requested row, exactly one DRAM command is issued, and no metadata read or write is issued. The response then has rsp_buf_hit=1.
- R3: rsp_hit is 1 exactly when the addressed block's slot is valid and its stored tag equals the request tag. A hit issues op DATA.
- R4: When the buffer does not hold the row and the indexed entry is invalid or clean, the command order is: MD_RD of the requested row, then the data command. The response then has rsp_buf_hit=0.
- R5: dram_row_hit is 1 on a data command that follows a metadata read in the same request. It is 0 on a data command issued from a buffer hit.
- R6: When a valid, dirty entry must be replaced, an MD_WR is issued first. It targets the victim row ({entry row tag, index}) and carries the entry's tags. The MD_RD follows in the next cycle after the MD_WR is accepted.
- R7: A cache miss issues op FILL and updates the buffer entry with the request tag. A later request for the same block hits. This holds even after the entry has been evicted and re-read, because the in-row copy is written back on eviction.
- R8: req_ready is 0 from the cycle after a request is accepted until the response has been given. Only one request is outstanding.
- R9: While dram_valid is 1 and dram_ready is 0, dram_valid stays 1, and dram_op, dram_row, dram_blk, dram_row_hit and dram_wtags stay unchanged.
- R10: The address is {tag[TAG_W], row[ROW_W], blk[BLK_W]}, with blk in the least significant bits. The buffer index is row[IDX_W-1:0]. The dram_op codes are DATA=0, FILL=1, MD_RD=2, MD_WR=3.
- R11: The metadata word holds NBLK slots of TAG_W+1 bits each. Slot b occupies bits [b*(TAG_W+1) +: TAG_W+1], and the most significant bit of each slot is its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_addr | input | ADDR_W | Request address {tag, row, blk} |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | DRAM cache hit |
| rsp_buf_hit | output | 1 | Row tags were found in the on-chip buffer |
| dram_valid | output | 1 | DRAM command present |
| dram_ready | input | 1 | DRAM accepts the command |
| dram_op | output | 2 | Command code (see R10) |
| dram_row | output | ROW_W | Target row |
| dram_blk | output | BLK_W | Target block in the row |
| dram_row_hit | output | 1 | Command is expected to hit the open row |
| dram_wtags | output | MD_W | Row metadata written by MD_WR |
| md_valid | input | 1 | Metadata read data returned |
| md_tags | input | MD_W | Returned row metadata (see R11) |

## Verification
The assertions assume the DRAM side never returns md_valid unless an MD_RD has been accepted. They also assume the DRAM returns exactly one metadata word per read. The bench's DRAM model keeps to this: it raises md_valid once, in the cycle after each accepted MD_RD, and answers from its own per-row metadata store, which it updates on every accepted MD_WR. Requests are offered only while req_ready is high. Stalls are created by holding dram_ready low for a set number of cycles on each command.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_WB, S_MDRD, S_MDWAIT, S_DATA, S_RESP
    } tbc_state_e;

    // R10 command encoding
    typedef enum logic [1:0] {
        OP_DATA  = 2'd0,
        OP_FILL  = 2'd1,
        OP_MD_RD = 2'd2,
        OP_MD_WR = 2'd3
    } tbc_op_e;
endpackage

// File: rtl/tbc_entry_array.sv
module tbc_entry_array #(
    parameter int IDX_W = 6,
    parameter int EW    = 40,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [EW-1:0]    rdata,
    input  logic             we,
    input  logic [EW-1:0]    wdata
);
    logic [EW-1:0] mem_q [DEPTH];

    assign rdata = mem_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end
endmodule

// File: rtl/tbc_slot_match.sv
module tbc_slot_match #(
    parameter int BLK_W = 2,
    parameter int TAG_W = 8,
    localparam int NBLK = 1 << BLK_W,
    localparam int SW   = TAG_W + 1,
    localparam int MD_W = NBLK * SW
) (
    input  logic [MD_W-1:0]  slots,
    input  logic [BLK_W-1:0] blk,
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [MD_W-1:0]  filled
);
    logic [NBLK-1:0] hit_vec;

    for (genvar b = 0; b < NBLK; b++) begin : g_slot
        logic [SW-1:0] cur;
        logic          sel;
        assign cur = slots[b*SW +: SW];
        assign sel = (blk == BLK_W'(b));
        assign hit_vec[b] = sel && cur[SW-1] && (cur[TAG_W-1:0] == tag);
        assign filled[b*SW +: SW] = sel ? {1'b1, tag} : cur;
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/tag_buffer_ctrl.sv
module tag_buffer_ctrl
    import tbc_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int BLK_W = 2,
    parameter int TAG_W = 8,
    parameter int IDX_W = 6,
    localparam int NBLK   = 1 << BLK_W,
    localparam int MD_W   = NBLK * (TAG_W + 1),
    localparam int RT_W   = ROW_W - IDX_W,
    localparam int ADDR_W = TAG_W + ROW_W + BLK_W,
    localparam int EW     = 2 + RT_W + MD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_buf_hit,
    output logic              dram_valid,
    input  logic              dram_ready,
    output logic [1:0]        dram_op,
    output logic [ROW_W-1:0]  dram_row,
    output logic [BLK_W-1:0]  dram_blk,
    output logic              dram_row_hit,
    output logic [MD_W-1:0]   dram_wtags,
    input  logic              md_valid,
    input  logic [MD_W-1:0]   md_tags
);
    typedef struct packed {
        tbc_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              from_miss;
        logic              buf_hit;
        logic              hit;
        tbc_op_e           op;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BLK_W-1:0] blk_q;
    logic [ROW_W-1:0] row_q;
    logic [TAG_W-1:0] tag_q;
    logic [IDX_W-1:0] idx_q;
    logic [RT_W-1:0]  rtag_q;

    assign blk_q  = ctl_q.addr[BLK_W-1:0];
    assign row_q  = ctl_q.addr[BLK_W +: ROW_W];
    assign tag_q  = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign idx_q  = row_q[IDX_W-1:0];
    assign rtag_q = row_q[ROW_W-1:IDX_W];

    logic [EW-1:0]   ent_rd, ent_wr;
    logic            ent_we;
    logic            ent_valid, ent_dirty;
    logic [RT_W-1:0] ent_rtag;
    logic [MD_W-1:0] ent_slots, fill_slots;
    logic            slot_hit;

    assign ent_valid = ent_rd[EW-1];
    assign ent_dirty = ent_rd[EW-2];
    assign ent_rtag  = ent_rd[MD_W +: RT_W];
    assign ent_slots = ent_rd[MD_W-1:0];

    tbc_entry_array #(.IDX_W(IDX_W), .EW(EW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (idx_q),
        .rdata (ent_rd),
        .we    (ent_we),
        .wdata (ent_wr)
    );

    tbc_slot_match #(.BLK_W(BLK_W), .TAG_W(TAG_W)) u_match (
        .slots  (ent_slots),
        .blk    (blk_q),
        .tag    (tag_q),
        .hit    (slot_hit),
        .filled (fill_slots)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ent_we       = 1'b0;
        ent_wr       = ent_rd;
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        rsp_hit      = ctl_q.hit;
        rsp_buf_hit  = ctl_q.buf_hit;
        dram_valid   = 1'b0;
        dram_op      = OP_DATA;
        dram_row     = row_q;
        dram_blk     = blk_q;
        dram_row_hit = 1'b0;
        dram_wtags   = ent_slots;

        unique case (ctl_q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ctl_d.addr      = req_addr;
                    ctl_d.from_miss = 1'b0;
                    ctl_d.st        = S_CHECK;
                end
            end
            S_CHECK: begin
                if (ent_valid && ent_rtag == rtag_q) begin
                    ctl_d.hit     = slot_hit;
                    ctl_d.buf_hit = !ctl_q.from_miss;
                    ctl_d.op      = slot_hit ? OP_DATA : OP_FILL;
                    ctl_d.st      = S_DATA;
                    if (!slot_hit) begin
                        ent_we = 1'b1;
                        ent_wr = {1'b1, 1'b1, ent_rtag, fill_slots};
                    end
                end else begin
                    ctl_d.from_miss = 1'b1;
                    ctl_d.st = (ent_valid && ent_dirty) ? S_WB : S_MDRD;
                end
            end
            S_WB: begin
                dram_valid = 1'b1;
                dram_op    = OP_MD_WR;
                dram_row   = {ent_rtag, idx_q};
                if (dram_ready) ctl_d.st = S_MDRD;
            end
            S_MDRD: begin
                dram_valid = 1'b1;
                dram_op    = OP_MD_RD;
                if (dram_ready) ctl_d.st = S_MDWAIT;
            end
            S_MDWAIT: begin
                if (md_valid) begin
                    ent_we   = 1'b1;
                    ent_wr   = {1'b1, 1'b0, rtag_q, md_tags};
                    ctl_d.st = S_CHECK;
                end
            end
            S_DATA: begin
                dram_valid   = 1'b1;
                dram_op      = ctl_q.op;
                dram_row_hit = ctl_q.from_miss;
                if (dram_ready) ctl_d.st = S_RESP;
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                ctl_d.st  = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, addr: '0, from_miss: 1'b0,
                       buf_hit: 1'b0, hit: 1'b0, op: OP_DATA};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/tbc_chk.sv
module tbc_chk #(
    parameter int ROW_W = 10,
    parameter int BLK_W = 2,
    parameter int MD_W  = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_buf_hit,
    input logic             dram_valid,
    input logic             dram_ready,
    input logic [1:0]       dram_op,
    input logic [ROW_W-1:0] dram_row,
    input logic [BLK_W-1:0] dram_blk,
    input logic             dram_row_hit,
    input logic [MD_W-1:0]  dram_wtags
);
    logic md_in_txn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         md_in_txn <= 1'b0;
        else if (req_valid && req_ready)                    md_in_txn <= 1'b0;
        else if (dram_valid && dram_ready && dram_op == 2'd2) md_in_txn <= 1'b1;
    end

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_valid && !dram_ready |=> dram_valid && $stable(dram_op) &&
        $stable(dram_row) && $stable(dram_blk) && $stable(dram_row_hit) &&
        $stable(dram_wtags));

    // R6
    wb_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_valid && dram_ready && dram_op == 2'd3 |=> dram_valid && dram_op == 2'd2);

    // R2
    buf_hit_no_md_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_buf_hit |-> !md_in_txn);

    // R4
    buf_miss_reads_md_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_buf_hit |-> md_in_txn);

    // R5
    row_hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_valid && dram_op[1] == 1'b0 |-> dram_row_hit == md_in_txn);
endmodule

bind tag_buffer_ctrl tbc_chk #(.ROW_W(ROW_W), .BLK_W(BLK_W), .MD_W(MD_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_buf_hit  (rsp_buf_hit),
    .dram_valid   (dram_valid),
    .dram_ready   (dram_ready),
    .dram_op      (dram_op),
    .dram_row     (dram_row),
    .dram_blk     (dram_blk),
    .dram_row_hit (dram_row_hit),
    .dram_wtags   (dram_wtags)
);

// File: tb/test_tag_buffer_ctrl.sv
module test_tag_buffer_ctrl;
    localparam int ROW_W = 10, BLK_W = 2, TAG_W = 8;
    localparam int MD_W = 4 * (TAG_W + 1);
    localparam int ADDR_W = TAG_W + ROW_W + BLK_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_valid, rsp_hit, rsp_buf_hit;
    logic dram_valid, dram_ready = 1'b0;
    logic [1:0] dram_op;
    logic [ROW_W-1:0] dram_row;
    logic [BLK_W-1:0] dram_blk;
    logic dram_row_hit;
    logic [MD_W-1:0] dram_wtags;
    logic md_valid = 1'b0;
    logic [MD_W-1:0] md_tags = '0;

    always #5 clk = ~clk;

    tag_buffer_ctrl i_tag_buffer_ctrl (.*);

    int n_chk = 0, n_bad = 0;
    logic [MD_W-1:0] md_mem [1 << ROW_W];

    // per-request observations
    int        o_ncmd, o_busy_err, o_hold_err;
    logic      o_bh, o_hit, o_last_rh;
    logic [1:0] o_fop, o_lop;
    logic [ROW_W-1:0] o_frow;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [ROW_W-1:0] row, input logic [BLK_W-1:0] blk,
                           input logic [TAG_W-1:0] tag, input int stall);
        int  st_cnt = 0;
        bit  md_next = 0, done = 0, have_snap = 0;
        logic [ROW_W+BLK_W+MD_W+3-1:0] snap;
        o_ncmd = 0; o_busy_err = 0; o_hold_err = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {tag, row, blk};
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 100 && !done; cyc++) begin
            if (req_ready) o_busy_err++;
            dram_ready = 1'b0;
            md_valid   = 1'b0;
            if (md_next) begin
                md_valid = 1'b1;
                md_next  = 0;
            end
            if (rsp_valid) begin
                o_bh = rsp_buf_hit; o_hit = rsp_hit; done = 1;
            end else if (dram_valid) begin
                if (have_snap && snap != {dram_op, dram_row_hit, dram_row, dram_blk, dram_wtags})
                    o_hold_err++;
                if (st_cnt < stall) begin
                    st_cnt++;
                    have_snap = 1;
                    snap = {dram_op, dram_row_hit, dram_row, dram_blk, dram_wtags};
                end else begin
                    dram_ready = 1'b1;
                    st_cnt = 0; have_snap = 0;
                    if (o_ncmd == 0) begin o_fop = dram_op; o_frow = dram_row; end
                    o_lop = dram_op; o_last_rh = dram_row_hit;
                    o_ncmd++;
                    if (dram_op == 2'd3) md_mem[dram_row] = dram_wtags;
                    if (dram_op == 2'd2) begin md_tags = md_mem[dram_row]; md_next = 1; end
                end
            end
            if (!done) @(negedge clk);
        end
        if (!done) check(0, "R8 response missing", 0, 1);
    endtask

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [BLK_W-1:0] blk;
        logic [TAG_W-1:0] tag;
        logic             bh;
        logic             hit;
        logic [1:0]       ncmd;
        logic [1:0]       fop;
        logic [ROW_W-1:0] frow;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{10'd5,  2'd0, 8'h11, 1'b0, 1'b0, 2'd2, 2'd2, 10'd5},
        '{10'd5,  2'd0, 8'h11, 1'b1, 1'b1, 2'd1, 2'd0, 10'd5},
        '{10'd5,  2'd1, 8'h22, 1'b1, 1'b0, 2'd1, 2'd1, 10'd5},
        '{10'd5,  2'd1, 8'h22, 1'b1, 1'b1, 2'd1, 2'd0, 10'd5},
        '{10'd69, 2'd0, 8'h11, 1'b0, 1'b0, 2'd3, 2'd3, 10'd5},
        '{10'd5,  2'd0, 8'h11, 1'b0, 1'b1, 2'd3, 2'd3, 10'd69},
        '{10'd5,  2'd0, 8'h33, 1'b1, 1'b0, 2'd1, 2'd1, 10'd5},
        '{10'd7,  2'd3, 8'h44, 1'b0, 1'b0, 2'd2, 2'd2, 10'd7},
        '{10'd7,  2'd3, 8'h44, 1'b1, 1'b1, 2'd1, 2'd0, 10'd7}
    };

    initial begin
        for (int i = 0; i < (1 << ROW_W); i++) md_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        check(dram_valid == 1'b0, "R1 dram_valid", dram_valid, 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 9; v++) begin
            run_req(VEC[v].row, VEC[v].blk, VEC[v].tag, 0);
            check(o_bh == VEC[v].bh, "R2/R4 rsp_buf_hit", o_bh, VEC[v].bh);
            check(o_hit == VEC[v].hit, "R3/R7 rsp_hit", o_hit, VEC[v].hit);
            check(o_ncmd == VEC[v].ncmd, "R2/R4/R6 command count", o_ncmd, VEC[v].ncmd);
            check(o_fop == VEC[v].fop, "R6/R10 first op", o_fop, VEC[v].fop);
            check(o_frow == VEC[v].frow, "R6 first row", o_frow, VEC[v].frow);
            check(o_lop == (VEC[v].hit ? 2'd0 : 2'd1), "R3/R7 data op", o_lop,
                  VEC[v].hit ? 2'd0 : 2'd1);
            check(o_last_rh == !VEC[v].bh, "R5 row hit flag", o_last_rh, !VEC[v].bh);
            check(o_busy_err == 0, "R8 req_ready while busy", o_busy_err, 0);
            // R11 write-back payload slot layout after step 5
            if (v == 4)
                check(md_mem[5] == {9'h0, 9'h0, 9'h122, 9'h111}, "R11 written tags",
                      md_mem[5], {9'h0, 9'h0, 9'h122, 9'h111});
        end

        // R9 stalls: evict dirty row 5 (blk0 now tag 33) via row 133
        run_req(10'd133, 2'd0, 8'h33, 3);
        check(o_hold_err == 0, "R9 held command", o_hold_err, 0);
        check(o_ncmd == 3, "R6 stalled wb count", o_ncmd, 3);
        check(o_frow == 10'd5, "R6 stalled victim row", o_frow, 5);
        // R7 consistency: row 5 re-read must hold tag 33
        run_req(10'd5, 2'd0, 8'h33, 2);
        check(o_hit == 1'b1, "R7 tag survives eviction", o_hit, 1);
        check(o_bh == 1'b0, "R4 re-read buffer miss", o_bh, 0);
        check(o_hold_err == 0, "R9 held command", o_hold_err, 0);
        // R10 index from low row bits: row 7+64 conflicts with row 7 (clean? dirty after fill)
        run_req(10'd71, 2'd3, 8'h44, 0);
        check(o_fop == 2'd3 && o_frow == 10'd7, "R10 index aliasing", o_frow, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule